// File: doc/BRIEF.md
# Write-Through Two-Way Data Cache with Store Queue

This block is a small data cache controller that sits between a processor port and a slower word-wide memory port. Lines are placed in a two-way set-associative array. Both ways of the selected set are compared at the same time, and the read word is picked from whichever way matched. Replacement uses one least-recently-used bit per set. A read that misses stalls the processor while the whole block is fetched one word at a time. After the fetch the held request completes as a hit.

Every store is written through. A store that hits also updates the cached word. Every store, hit or miss, is queued in a four-entry FIFO store queue, and the queue empties into memory on its own while the processor keeps running. A store that misses allocates nothing. A read miss first waits until the queue is empty, so the block it fetches already holds every earlier store.

The controller is built around a three-state machine. In `ST_IDLE` it serves hits and accepts stores. On a read miss it moves to `ST_DRAIN` when stores are still queued ("miss_pending"), or straight to `ST_FILL` when the queue is empty ("miss_clean"). It leaves `ST_DRAIN` for `ST_FILL` once the queue is empty ("drained"). It returns from `ST_FILL` to `ST_IDLE` when the last word of the block arrives ("filled").

Top module: `wt_cache`

## Requirements
- R1: After reset no memory request is raised, the store queue is empty and every line is invalid, so the first read of any address misses.
- R2: Addresses are byte addresses that must be word aligned (bits [1:0] zero). Bits [3:2] select a word in the 4-word block, bits [5:4] select one of 4 sets and bits [15:6] form the tag. A read hit is accepted in the cycle it is presented, with no stall, and the read data is valid in that same cycle.
- R3: A read miss fetches the whole block as 4 memory reads at the block's word addresses, in order from word 0 to word 3. The stalled request then completes with the correct word, and reads of the other words of that block hit.
- R4: Two blocks with different tags in the same set are both resident after being fetched, and both hit.
- R5: A miss in a set whose two ways are both valid replaces the least recently used way. A read hit makes the way that hit the most recently used one.
- R6: A store that hits updates the cached word, and a later read returns the new value with no stall.
- R7: A store that misses allocates no line. A later read of that address misses and returns the stored value.
- R8: Every accepted store becomes exactly one memory write with the same address and data, and the writes reach memory in the order the stores were accepted.
- R9: The store queue holds 4 entries. A store is accepted without stall while the queue is not full and is stalled while it is full.
- R10: On a read miss, every queued store is written to memory before the first read of the block fetch.
- R11: The processor stays stalled for the whole block fetch, which takes at least 4 memory transactions.
- R12: A memory request keeps its command, address and write data unchanged until the cycle in which done is seen, and each done pulse completes exactly one transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request valid, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Word-aligned byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_rdata | output | 32 | Load data, valid while cpu_ready for a load |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_done |
| mem_done | input | 1 | One-cycle pulse ending the current transaction |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, 32-bit words, 4 sets of two 4-word ways, and a 4-entry store queue. With only 4 sets, a 1 KiB memory model already gives each set several competing tags, so evictions and the recency update can be driven directly. The shallow queue combined with a memory latency the bench can raise lets five back-to-back stores reach the full-queue stall, and lets a read miss land while stores are still queued, which exercises the drain-before-fetch ordering.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_FILL  = 2'd2
    } ctrl_state_e;

endpackage

// File: rtl/wtc_ways.sv
module wtc_ways #(
    parameter int SETS   = 4,
    parameter int WORDS  = 4,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WOFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [WOFF_W-1:0] lk_word,
    output logic              hit,
    output logic              hit_way,
    output logic [DATA_W-1:0] rd_data,
    output logic              victim_way,
    input  logic              st_en,
    input  logic              st_way,
    input  logic [IDX_W-1:0]  st_idx,
    input  logic [WOFF_W-1:0] st_word,
    input  logic [DATA_W-1:0] st_data,
    input  logic              fl_en,
    input  logic              fl_way,
    input  logic [IDX_W-1:0]  fl_idx,
    input  logic [WOFF_W-1:0] fl_word,
    input  logic [TAG_W-1:0]  fl_tag,
    input  logic [DATA_W-1:0] fl_data,
    input  logic              fl_last,
    input  logic              touch_en,
    input  logic [IDX_W-1:0]  touch_idx,
    input  logic              touch_way
);

    localparam int NWAYS = 2;

    logic [NWAYS-1:0]             match;
    logic [NWAYS-1:0]             set_valid;
    logic [NWAYS-1:0][DATA_W-1:0] way_word;
    logic [SETS-1:0]              lru_q;   // per set: index of least recently used way

    for (genvar g = 0; g < NWAYS; g++) begin : g_way
        logic [SETS-1:0]   valid_q;
        logic [TAG_W-1:0]  tag_q  [SETS];
        logic [DATA_W-1:0] data_q [SETS*WORDS];
        logic              fl_mine;
        logic              st_mine;

        assign fl_mine = fl_en && (fl_way == 1'(g));
        assign st_mine = st_en && (st_way == 1'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= '0;
            end else if (fl_mine) begin
                if (fl_last) begin
                    valid_q[fl_idx] <= 1'b1;
                end else if (fl_word == '0) begin
                    valid_q[fl_idx] <= 1'b0;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (fl_mine && fl_last) begin
                tag_q[fl_idx] <= fl_tag;
            end
        end

        always_ff @(posedge clk) begin
            if (fl_mine) begin
                data_q[{fl_idx, fl_word}] <= fl_data;
            end else if (st_mine) begin
                data_q[{st_idx, st_word}] <= st_data;
            end
        end

        assign set_valid[g] = valid_q[lk_idx];
        assign match[g]     = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        assign way_word[g]  = data_q[{lk_idx, lk_word}];
    end

    // Hit is the OR of the way matches; data is steered by the match lines.
    assign hit     = |match;
    assign hit_way = match[1];

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NWAYS; w++) begin
            rd_data = rd_data | ({DATA_W{match[w]}} & way_word[w]);
        end
    end

    always_comb begin
        if (!set_valid[0]) begin
            victim_way = 1'b0;
        end else if (!set_valid[1]) begin
            victim_way = 1'b1;
        end else begin
            victim_way = lru_q[lk_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[touch_idx] <= ~touch_way;
        end
    end

    // R4: a block is never resident in both ways of its set
    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
    parameter int DEPTH = 4,
    parameter int W     = 46,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;

    assign full  = (cnt_q == FULL_CNT);
    assign empty = (cnt_q == '0);
    assign head  = slot_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop) begin
                rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
            end
            if (push && !pop) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (pop && !push) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R9: a store is never queued into a full buffer
    a_r9_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R8: a memory write completion always has a queued store behind it
    a_r8_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int WOFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              hit,
    input  logic              wb_full,
    input  logic              wb_empty,
    input  logic              mem_done,
    output logic              cpu_ready,
    output logic              wb_push,
    output logic              wb_pop,
    output logic              st_hit_en,
    output logic              hit_touch,
    output logic              miss_capture,
    output logic              in_fill,
    output logic              fill_en,
    output logic              fill_last,
    output logic [WOFF_W-1:0] fill_word
);

    localparam logic [WOFF_W-1:0] LAST_WORD = WOFF_W'(WORDS - 1);

    ctrl_state_e       state_q, state_d;
    logic [WOFF_W-1:0] word_q;
    logic              read_miss;

    assign read_miss = cpu_req && !cpu_we && !hit;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (read_miss) begin
                    state_d = wb_empty ? ST_FILL : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (wb_empty) begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_done && (word_q == LAST_WORD)) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and fill word counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_FILL) && mem_done) begin
                word_q <= (word_q == LAST_WORD) ? '0 : word_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cpu_ready    = 1'b0;
        wb_push      = 1'b0;
        st_hit_en    = 1'b0;
        hit_touch    = 1'b0;
        miss_capture = 1'b0;
        in_fill      = 1'b0;
        fill_en      = 1'b0;
        fill_last    = 1'b0;
        wb_pop       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        cpu_ready = !wb_full;
                        wb_push   = !wb_full;
                        st_hit_en = !wb_full && hit;
                        hit_touch = !wb_full && hit;
                    end else begin
                        cpu_ready    = hit;
                        hit_touch    = hit;
                        miss_capture = !hit;
                    end
                end
                wb_pop = mem_done && !wb_empty;
            end
            ST_DRAIN: begin
                wb_pop = mem_done && !wb_empty;
            end
            ST_FILL: begin
                in_fill   = 1'b1;
                fill_en   = mem_done;
                fill_last = mem_done && (word_q == LAST_WORD);
            end
            default: ;
        endcase
    end

    assign fill_word = word_q;

endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int SETS     = 4,
    parameter int WORDS    = 4,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_done
);

    localparam int BYTE_W  = $clog2(DATA_W / 8);
    localparam int WOFF_W  = $clog2(WORDS);
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - IDX_W - WOFF_W - BYTE_W;
    localparam int WADDR_W = ADDR_W - BYTE_W;
    localparam int ENTRY_W = WADDR_W + DATA_W;

    // address fields of the processor request
    logic [TAG_W-1:0]  cpu_tag;
    logic [IDX_W-1:0]  cpu_idx;
    logic [WOFF_W-1:0] cpu_word;

    assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_idx  = cpu_addr[BYTE_W+WOFF_W +: IDX_W];
    assign cpu_word = cpu_addr[BYTE_W +: WOFF_W];

    logic              hit, hit_way, victim_way;
    logic              wb_push, wb_pop, wb_full, wb_empty;
    logic              st_hit_en, hit_touch, miss_capture;
    logic              in_fill, fill_en, fill_last;
    logic [WOFF_W-1:0] fill_word;
    logic [ENTRY_W-1:0] wb_head;

    // block fetch target, captured when the miss is seen
    logic [TAG_W-1:0] fill_tag_q;
    logic [IDX_W-1:0] fill_idx_q;
    logic             fill_way_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_tag_q <= '0;
            fill_idx_q <= '0;
            fill_way_q <= 1'b0;
        end else if (miss_capture) begin
            fill_tag_q <= cpu_tag;
            fill_idx_q <= cpu_idx;
            fill_way_q <= victim_way;
        end
    end

    wtc_ctrl #(
        .WORDS (WORDS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .hit          (hit),
        .wb_full      (wb_full),
        .wb_empty     (wb_empty),
        .mem_done     (mem_done),
        .cpu_ready    (cpu_ready),
        .wb_push      (wb_push),
        .wb_pop       (wb_pop),
        .st_hit_en    (st_hit_en),
        .hit_touch    (hit_touch),
        .miss_capture (miss_capture),
        .in_fill      (in_fill),
        .fill_en      (fill_en),
        .fill_last    (fill_last),
        .fill_word    (fill_word)
    );

    wtc_ways #(
        .SETS   (SETS),
        .WORDS  (WORDS),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_ways (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (cpu_idx),
        .lk_tag     (cpu_tag),
        .lk_word    (cpu_word),
        .hit        (hit),
        .hit_way    (hit_way),
        .rd_data    (cpu_rdata),
        .victim_way (victim_way),
        .st_en      (st_hit_en),
        .st_way     (hit_way),
        .st_idx     (cpu_idx),
        .st_word    (cpu_word),
        .st_data    (cpu_wdata),
        .fl_en      (fill_en),
        .fl_way     (fill_way_q),
        .fl_idx     (fill_idx_q),
        .fl_word    (fill_word),
        .fl_tag     (fill_tag_q),
        .fl_data    (mem_rdata),
        .fl_last    (fill_last),
        .touch_en   (hit_touch || fill_last),
        .touch_idx  (in_fill ? fill_idx_q : cpu_idx),
        .touch_way  (in_fill ? fill_way_q : hit_way)
    );

    wtc_wbuf #(
        .DEPTH (WB_DEPTH),
        .W     (ENTRY_W)
    ) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wb_push),
        .push_data ({cpu_addr[ADDR_W-1:BYTE_W], cpu_wdata}),
        .pop       (wb_pop),
        .head      (wb_head),
        .full      (wb_full),
        .empty     (wb_empty)
    );

    // memory port: block fetch owns it in ST_FILL, the store queue otherwise
    always_comb begin
        mem_wdata = wb_head[DATA_W-1:0];
        if (in_fill) begin
            mem_req  = 1'b1;
            mem_we   = 1'b0;
            mem_addr = {fill_tag_q, fill_idx_q, fill_word, {BYTE_W{1'b0}}};
        end else begin
            mem_req  = !wb_empty;
            mem_we   = 1'b1;
            mem_addr = {wb_head[ENTRY_W-1:DATA_W], {BYTE_W{1'b0}}};
        end
    end

    // R2: processor addresses are word aligned
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cpu_addr[BYTE_W-1:0] == '0));

    // R2: a load is only accepted when the way compare found it
    a_r2_read_ready_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_ready) |-> hit);

    // R8: an accepted store is held in the queue on the next cycle
    a_r8_store_queued: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_ready) |=> !wb_empty);

    // R10: a block fetch read is only issued with the store queue empty
    a_r10_fill_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> wb_empty);

    // R12: a pending memory command is held until done
    a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                    && (!mem_we || $stable(mem_wdata))));

endmodule

// File: tb/test_wt_cache.sv
module test_wt_cache;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_done = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wt_cache i_wt_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_done  (mem_done)
    );

    // memory model (1 KiB) with programmable latency and a transaction log
    logic [31:0] mem_arr [256];
    logic [31:0] shadow  [256];
    int          mem_lat = 2;
    int          lat_cnt = 0;
    logic        log_we   [64];
    logic [15:0] log_addr [64];
    logic [31:0] log_data [64];
    int          log_n = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_done <= 1'b0;
            lat_cnt  <= 0;
        end else if (mem_done) begin
            mem_done <= 1'b0;
            lat_cnt  <= 0;
        end else if (mem_req) begin
            if (lat_cnt >= mem_lat) begin
                mem_done <= 1'b1;
                if (log_n < 64) begin
                    log_we[log_n]   = mem_we;
                    log_addr[log_n] = mem_addr;
                    log_data[log_n] = mem_we ? mem_wdata : mem_arr[mem_addr[9:2]];
                    log_n = log_n + 1;
                end
                if (mem_we) mem_arr[mem_addr[9:2]] <= mem_wdata;
                else        mem_rdata <= mem_arr[mem_addr[9:2]];
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic cpu_access(input bit we, input logic [15:0] a, input logic [31:0] wd,
                              output logic [31:0] rd, output int stall);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        stall = 0;
        #1;
        while (!cpu_ready && stall < 3000) begin
            @(negedge clk);
            #1;
            stall++;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (we) shadow[a[9:2]] = wd;
    endtask

    task automatic do_read(input logic [15:0] a, input bit exp_miss, input string tag);
        logic [31:0] rd;
        int st;
        cpu_access(1'b0, a, '0, rd, st);
        chk({tag, " read data"}, rd, shadow[a[9:2]]);
        chk({tag, " miss/stall"}, 32'(st > 0), 32'(exp_miss));
    endtask

    task automatic do_store(input logic [15:0] a, input logic [31:0] d, output int st);
        logic [31:0] rd;
        cpu_access(1'b1, a, d, rd, st);
    endtask

    task automatic wait_drain();
        int n = 0;
        @(negedge clk);
        while ((mem_req || mem_done) && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // R1, R2, R3, R11, R12: reset state and the first block fetch
    task automatic t_reset_and_fill();
        logic [31:0] rd;
        int st;
        chk("R1 mem_req after reset", 32'(mem_req), 32'd0);
        chk("R1 cpu_ready idle", 32'(cpu_ready), 32'd0);
        log_n = 0;
        cpu_access(1'b0, 16'h0018, '0, rd, st);
        chk("R3 miss returns word", rd, shadow[8'h06]);
        chk("R1 first read misses", 32'(st > 0), 32'd1);
        chk("R11 stall covers fetch", 32'(st >= 4 * (mem_lat + 1)), 32'd1);
        chk("R12 one done per word", 32'(log_n), 32'd4);
        for (int k = 0; k < 4; k++) begin
            chk("R3 fetch is read", 32'(log_we[k]), 32'd0);
            chk("R3 fetch word order", 32'(log_addr[k]), 32'(16'h0010 + 16'(4 * k)));
        end
        do_read(16'h0010, 1'b0, "R2 hit word0");
        do_read(16'h001C, 1'b0, "R3 hit word3");
        chk("R2 no memory on hit", 32'(log_n), 32'd4);
    endtask

    // R4, R5: two ways and replacement order in set 1
    task automatic t_ways_lru();
        do_read(16'h0050, 1'b1, "R4 tag1 fetch");
        do_read(16'h0090, 1'b1, "R4 tag2 fetch");
        do_read(16'h0054, 1'b0, "R4 tag1 resident");
        do_read(16'h0094, 1'b0, "R4 tag2 resident");
        do_read(16'h0050, 1'b0, "R5 touch tag1");
        do_read(16'h00D0, 1'b1, "R5 tag3 fetch");
        do_read(16'h0058, 1'b0, "R5 recent tag1 kept");
        do_read(16'h00D4, 1'b0, "R5 tag3 resident");
        do_read(16'h0090, 1'b1, "R5 tag2 evicted");
        do_read(16'h00D8, 1'b0, "R5 tag3 kept after tag1 lru");
        do_read(16'h0050, 1'b1, "R5 tag1 evicted");
    endtask

    // R6, R8: store hit updates the line and is written through
    task automatic t_store_hit();
        int st;
        do_read(16'h0100, 1'b1, "R6 prefetch");
        log_n = 0;
        do_store(16'h0104, 32'hA5A5_0104, st);
        chk("R6 store hit no stall", 32'(st), 32'd0);
        do_read(16'h0104, 1'b0, "R6 read after store");
        wait_drain();
        chk("R8 one write", 32'(log_n), 32'd1);
        chk("R8 write addr", 32'(log_addr[0]), 32'h0104);
        chk("R8 write data", log_data[0], 32'hA5A5_0104);
        chk("R8 memory updated", mem_arr[8'h41], 32'hA5A5_0104);
    endtask

    // R7: store miss does not allocate
    task automatic t_store_miss();
        int st;
        do_store(16'h0200, 32'h5151_0200, st);
        chk("R7 store miss no stall", 32'(st), 32'd0);
        wait_drain();
        do_read(16'h0200, 1'b1, "R7 no allocate");
    endtask

    // R8, R9: queue depth and full stall under long latency
    task automatic t_queue_full();
        int st [5];
        wait_drain();
        mem_lat = 20;
        log_n = 0;
        for (int k = 0; k < 5; k++) begin
            do_store(16'h0300 + 16'(4 * k), 32'hBEEF_0000 + 32'(k), st[k]);
        end
        for (int k = 0; k < 4; k++) begin
            chk("R9 store accepted without stall", 32'(st[k]), 32'd0);
        end
        chk("R9 fifth store stalls", 32'(st[4] > 0), 32'd1);
        wait_drain();
        chk("R8 write count", 32'(log_n), 32'd5);
        for (int k = 0; k < 5; k++) begin
            chk("R8 write order addr", 32'(log_addr[k]), 32'(16'h0300 + 16'(4 * k)));
            chk("R8 write order data", log_data[k], 32'hBEEF_0000 + 32'(k));
        end
        mem_lat = 2;
    endtask

    // R10: a read miss behind queued stores sees their data
    task automatic t_drain_first();
        int st;
        wait_drain();
        mem_lat = 10;
        log_n = 0;
        do_store(16'h03C0, 32'hC0C0_03C0, st);
        do_store(16'h03C8, 32'hC0C0_03C8, st);
        do_read(16'h03C0, 1'b1, "R10 read behind store");
        do_read(16'h03C8, 1'b0, "R10 second stored word");
        chk("R10 first op is write", 32'(log_we[0]), 32'd1);
        chk("R10 second op is write", 32'(log_we[1]), 32'd1);
        chk("R10 fetch after drain", 32'(log_we[2]), 32'd0);
        chk("R10 fetch starts at word0", 32'(log_addr[2]), 32'h03C0);
        mem_lat = 2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_arr[i] = 32'h7000_0000 + 32'(i * 3);
            shadow[i]  = 32'h7000_0000 + 32'(i * 3);
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_fill();
        t_ways_lru();
        t_store_hit();
        t_store_miss();
        t_queue_full();
        t_drain_first();
        wait_drain();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule